// File: doc/BRIEF.md
# Halfword Signed DSP Multiply-Accumulate

This unit computes 32-bit results from signed 16-bit lanes of two 32-bit operands `rn` and `rm`, with an optional 32-bit addend `ra`. A 5-bit opcode selects one of eight operation classes. Single halfword products can use either lane of each operand. Dual products add or subtract two lane products, and an exchange bit swaps the lanes of `rm`. A word-by-halfword product keeps bits [47:16] of the 48-bit product.

Every accumulating class, and both dual-add classes, report signed overflow of the exact result. A sticky saturation flag records that overflow. The result, the flag update pulse and the done strobe are registered one cycle after `valid`.

Top module: `hdsp_mac`

## Requirements
- R1: The opcode is `{class[2:0], a, b}`. Class 0 returns the single product `lane(rn,a) * lane(rm,b)`, where a lane select of 0 means bits [15:0] and 1 means bits [31:16]. Each lane is sign-extended before it is multiplied, and `ra` is ignored.
- R2: Class 1 returns the selected single product plus `ra`.
- R3: Class 2 returns `hi(rn)*hi(rm) + lo(rn)*lo(rm)`. With b=1 it returns `hi(rn)*lo(rm) + lo(rn)*hi(rm)` instead. Class 3 adds `ra` to the same sum.
- R4: Class 4 returns `lo(rn)*lo(rm) - hi(rn)*hi(rm)`. With b=1 it returns `lo(rn)*hi(rm) - hi(rn)*lo(rm)` instead. Class 5 adds `ra` to the same difference.
- R5: Class 6 returns bits [47:16] of `signed(rn) * lane(rm,b)`. Class 7 first adds `ra` shifted left by 16, then shifts the sum arithmetically right by 16.
- R6: For classes 1, 2, 3, 5 and 7, `q_hit` pulses together with `done` exactly when bit 32 of the exact signed result differs from bit 31.
- R7: Classes 0, 4 and 6 never raise `q_hit` and never set `q_flag`.
- R8: `q_flag` is sticky: it is set by a `q_hit` event and cleared one cycle after `q_clr`. When a set and a clear fall in the same cycle, the set wins.
- R9: `result` and `done` appear one clock after `valid`. `done` is high for one cycle per accepted operation, and `result` holds its value while `valid` is low.
- R10: After reset, `result` is 0 and `done`, `q_hit` and `q_flag` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| valid | input | 1 | Operation strobe |
| opcode | input | 5 | Class in [4:2]; lane, exchange or half select in [1:0] |
| rn | input | 32 | First operand |
| rm | input | 32 | Second operand |
| ra | input | 32 | Accumulator addend |
| q_clr | input | 1 | Clears the sticky flag |
| result | output | 32 | Registered result |
| q_hit | output | 1 | Overflow update pulse, aligned with done |
| q_flag | output | 1 | Sticky saturation flag |
| done | output | 1 | Result valid pulse |

## Verification
The assertions check the timing contract on every cycle: `done` follows `valid` by exactly one cycle, the result holds while idle, `q_hit` never appears without `done`, the non-flagging classes stay quiet, and `q_flag` sticks or clears as R8 requires. Arithmetic correctness cannot be checked that way. Lane selection, exchange pairing, the 48-bit window of the word product and the exact overflow boundaries (for example −32768·−32768 summed twice, or a maximum `ra` with a maximum word product) are shown only by the bench's vector table and its directed sequences.

// File: rtl/hdsp_pkg.sv
package hdsp_pkg;

   localparam int OP_W = 5;

   typedef enum logic [2:0] {
      CL_MUL   = 3'd0,
      CL_MLA   = 3'd1,
      CL_DADD  = 3'd2,
      CL_DADDA = 3'd3,
      CL_DSUB  = 3'd4,
      CL_DSUBA = 3'd5,
      CL_MULW  = 3'd6,
      CL_MLAW  = 3'd7
   } op_cls_e;

   // classes whose overflow reaches the sticky flag
   function automatic logic cls_flags_q(op_cls_e c);
      return !(c == CL_MUL || c == CL_DSUB || c == CL_MULW);
   endfunction

endpackage

// File: rtl/hdsp_lanes.sv
// Splits both operands into halfword lanes and steers them to the multipliers.
module hdsp_lanes #(
   parameter int DW = 32
) (
   input  logic [DW-1:0]   rn,
   input  logic [DW-1:0]   rm,
   input  logic            sel_rn_top,
   input  logic            sel_rm_top,
   input  logic            swap,
   output logic [DW/2-1:0] rn_one,
   output logic [DW/2-1:0] rm_one,
   output logic [DW/2-1:0] hp_a,
   output logic [DW/2-1:0] hp_b,
   output logic [DW/2-1:0] lp_a,
   output logic [DW/2-1:0] lp_b
);
   localparam int HW = DW / 2;

   logic [DW-1:0] opnd   [2];
   logic          sel    [2];
   logic [HW-1:0] lo_h   [2];
   logic [HW-1:0] hi_h   [2];
   logic [HW-1:0] pick_h [2];

   assign opnd[0] = rn;
   assign opnd[1] = rm;
   assign sel[0]  = sel_rn_top;
   assign sel[1]  = sel_rm_top;

   generate
      for (genvar g = 0; g < 2; g++) begin : g_opnd
         assign lo_h[g]   = opnd[g][HW-1:0];
         assign hi_h[g]   = opnd[g][DW-1:HW];
         assign pick_h[g] = sel[g] ? hi_h[g] : lo_h[g];
      end
   endgenerate

   assign rn_one = pick_h[0];
   assign rm_one = pick_h[1];

   // high pair: hi(rn) with hi(rm), or lo(rm) when exchanged
   assign hp_a = hi_h[0];
   assign hp_b = swap ? lo_h[1] : hi_h[1];
   // low pair: lo(rn) with lo(rm), or hi(rm) when exchanged
   assign lp_a = lo_h[0];
   assign lp_b = swap ? hi_h[1] : lo_h[1];

endmodule

// File: rtl/hdsp_mults.sv
// Signed multipliers: one single-lane, two dual-lane, one word-by-halfword.
module hdsp_mults #(
   parameter int DW = 32
) (
   input  logic [DW-1:0]        rn,
   input  logic [DW/2-1:0]      rn_one,
   input  logic [DW/2-1:0]      rm_one,
   input  logic [DW/2-1:0]      hp_a,
   input  logic [DW/2-1:0]      hp_b,
   input  logic [DW/2-1:0]      lp_a,
   input  logic [DW/2-1:0]      lp_b,
   output logic [DW-1:0]        p_one,
   output logic [DW-1:0]        p_hi,
   output logic [DW-1:0]        p_lo,
   output logic [DW+DW/2-1:0]   p_word
);
   localparam int HW = DW / 2;
   localparam int PW = DW + HW;

   logic signed [DW-1:0] x_rn1, x_rm1, x_ha, x_hb, x_la, x_lb;
   logic signed [PW-1:0] x_rnw, x_rmw;

   assign x_rn1 = {{HW{rn_one[HW-1]}}, rn_one};
   assign x_rm1 = {{HW{rm_one[HW-1]}}, rm_one};
   assign x_ha  = {{HW{hp_a[HW-1]}}, hp_a};
   assign x_hb  = {{HW{hp_b[HW-1]}}, hp_b};
   assign x_la  = {{HW{lp_a[HW-1]}}, lp_a};
   assign x_lb  = {{HW{lp_b[HW-1]}}, lp_b};
   assign x_rnw = {{HW{rn[DW-1]}}, rn};
   assign x_rmw = {{DW{rm_one[HW-1]}}, rm_one};

   assign p_one  = x_rn1 * x_rm1;
   assign p_hi   = x_ha * x_hb;
   assign p_lo   = x_la * x_lb;
   assign p_word = x_rnw * x_rmw;

endmodule

// File: rtl/hdsp_merge.sv
// Combines products and addend per class, and detects overflow of the exact result.
module hdsp_merge
   import hdsp_pkg::*;
#(
   parameter int DW = 32
) (
   input  op_cls_e              cls,
   input  logic [DW-1:0]        ra,
   input  logic [DW-1:0]        p_one,
   input  logic [DW-1:0]        p_hi,
   input  logic [DW-1:0]        p_lo,
   input  logic [DW+DW/2-1:0]   p_word,
   output logic [DW-1:0]        res,
   output logic                 q_upd
);
   localparam int HW = DW / 2;
   localparam int PW = DW + HW;
   localparam int WW = PW + 2;
   localparam int TOP_W = WW - DW + 1;

   logic signed [WW-1:0] ra_w, one_w, hi_w, lo_w, word_w, wide;
   logic [TOP_W-1:0]     top_bits;
   logic                 ovf;

   assign ra_w   = {{(WW-DW){ra[DW-1]}}, ra};
   assign one_w  = {{(WW-DW){p_one[DW-1]}}, p_one};
   assign hi_w   = {{(WW-DW){p_hi[DW-1]}}, p_hi};
   assign lo_w   = {{(WW-DW){p_lo[DW-1]}}, p_lo};
   assign word_w = {{(WW-PW){p_word[PW-1]}}, p_word};

   always_comb begin
      unique case (cls)
         CL_MUL:   wide = one_w;
         CL_MLA:   wide = one_w + ra_w;
         CL_DADD:  wide = hi_w + lo_w;
         CL_DADDA: wide = hi_w + lo_w + ra_w;
         CL_DSUB:  wide = lo_w - hi_w;
         CL_DSUBA: wide = lo_w - hi_w + ra_w;
         CL_MULW:  wide = word_w >>> HW;
         CL_MLAW:  wide = (word_w + (ra_w <<< HW)) >>> HW;
         default:  wide = one_w;
      endcase
   end

   // exact signed overflow: bits above the sign bit of the result disagree
   assign top_bits = wide[WW-1:DW-1];
   assign ovf      = !((&top_bits) || !(|top_bits));
   assign res      = wide[DW-1:0];
   assign q_upd    = cls_flags_q(cls) && ovf;

endmodule

// File: rtl/hdsp_mac.sv
module hdsp_mac
   import hdsp_pkg::*;
#(
   parameter int DW = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               valid,
   input  logic [OP_W-1:0]    opcode,
   input  logic [DW-1:0]      rn,
   input  logic [DW-1:0]      rm,
   input  logic [DW-1:0]      ra,
   input  logic               q_clr,
   output logic [DW-1:0]      result,
   output logic               q_hit,
   output logic               q_flag,
   output logic               done
);
   localparam int HW = DW / 2;
   localparam int PW = DW + HW;

   generate
      if ((DW % 2) != 0 || DW < 8) begin : g_bad_dw
         $error("hdsp_mac: DW must be even and at least 8");
      end
   endgenerate

   op_cls_e        cls;
   logic [HW-1:0]  rn_one, rm_one, hp_a, hp_b, lp_a, lp_b;
   logic [DW-1:0]  p_one, p_hi, p_lo, res_c;
   logic [PW-1:0]  p_word;
   logic           q_upd_c;

   assign cls = op_cls_e'(opcode[4:2]);

   hdsp_lanes #(.DW(DW)) u_lanes (
      .rn(rn), .rm(rm),
      .sel_rn_top(opcode[1]), .sel_rm_top(opcode[0]), .swap(opcode[0]),
      .rn_one(rn_one), .rm_one(rm_one),
      .hp_a(hp_a), .hp_b(hp_b), .lp_a(lp_a), .lp_b(lp_b)
   );

   hdsp_mults #(.DW(DW)) u_mults (
      .rn(rn), .rn_one(rn_one), .rm_one(rm_one),
      .hp_a(hp_a), .hp_b(hp_b), .lp_a(lp_a), .lp_b(lp_b),
      .p_one(p_one), .p_hi(p_hi), .p_lo(p_lo), .p_word(p_word)
   );

   hdsp_merge #(.DW(DW)) u_merge (
      .cls(cls), .ra(ra),
      .p_one(p_one), .p_hi(p_hi), .p_lo(p_lo), .p_word(p_word),
      .res(res_c), .q_upd(q_upd_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result <= '0;
         done   <= 1'b0;
         q_hit  <= 1'b0;
         q_flag <= 1'b0;
      end else begin
         done   <= valid;
         q_hit  <= valid && q_upd_c;
         q_flag <= (q_flag && !q_clr) || (valid && q_upd_c);
         if (valid) result <= res_c;
      end
   end

   // R9
   done_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid |=> done);
   // R9
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !valid |=> (!done && $stable(result)));
   // R6
   hit_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      q_hit |-> (done && q_flag));
   // R7
   quiet_cls_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !cls_flags_q(cls)) |=> !q_hit);
   // R8
   q_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (q_flag && !q_clr) |=> q_flag);
   // R8
   q_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (q_clr && !(valid && q_upd_c)) |=> !q_flag);

endmodule

// File: tb/hdsp_mac_tb.sv
module hdsp_mac_tb;

   typedef struct packed {
      logic [4:0]  op;
      logic [31:0] rn;
      logic [31:0] rm;
      logic [31:0] ra;
      logic [31:0] res;
      logic        ovf;
   } vec_t;

   localparam int NV = 22;
   localparam vec_t VEC [NV] = '{
      '{5'b00000, 32'h00070002, 32'h0005FFFD, 32'h12345678, 32'hFFFFFFFA, 1'b0},
      '{5'b00011, 32'h00070002, 32'h0005FFFD, 32'h00000000, 32'h00000023, 1'b0},
      '{5'b00010, 32'h00070002, 32'h0005FFFD, 32'h00000000, 32'hFFFFFFEB, 1'b0},
      '{5'b00001, 32'h00070002, 32'h0005FFFD, 32'h00000000, 32'h0000000A, 1'b0},
      '{5'b00000, 32'h00008000, 32'h00008000, 32'h00000000, 32'h40000000, 1'b0},
      '{5'b00100, 32'h00000010, 32'h00000010, 32'h00000100, 32'h00000200, 1'b0},
      '{5'b00111, 32'hFFFF0000, 32'h00020000, 32'h00000001, 32'hFFFFFFFF, 1'b0},
      '{5'b00100, 32'h00008000, 32'h00008000, 32'h40000000, 32'h80000000, 1'b1},
      '{5'b01000, 32'h00030004, 32'h00050006, 32'h00000000, 32'h00000027, 1'b0},
      '{5'b01001, 32'h00030004, 32'h00050006, 32'h00000000, 32'h00000026, 1'b0},
      '{5'b01000, 32'h80008000, 32'h80008000, 32'h00000000, 32'h80000000, 1'b1},
      '{5'b01100, 32'h00030004, 32'h00050006, 32'hFFFFFFFF, 32'h00000026, 1'b0},
      '{5'b01100, 32'h80008000, 32'h7FFF7FFF, 32'h80000000, 32'h00010000, 1'b1},
      '{5'b10000, 32'h00030004, 32'h00050006, 32'h00000000, 32'h00000009, 1'b0},
      '{5'b10001, 32'h00030004, 32'h00050006, 32'h00000000, 32'h00000002, 1'b0},
      '{5'b10000, 32'h7FFF8000, 32'h80008000, 32'h00000000, 32'h7FFF8000, 1'b0},
      '{5'b10100, 32'h00000001, 32'h00000001, 32'h7FFFFFFF, 32'h80000000, 1'b1},
      '{5'b11000, 32'h00010000, 32'h00000003, 32'h00000000, 32'h00000003, 1'b0},
      '{5'b11001, 32'hFFFF0000, 32'h00050000, 32'h00000000, 32'hFFFFFFFB, 1'b0},
      '{5'b11000, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 32'hFFFFFFFF, 1'b0},
      '{5'b11100, 32'h00010000, 32'h00000002, 32'h00000005, 32'h00000007, 1'b0},
      '{5'b11100, 32'h7FFFFFFF, 32'h00007FFF, 32'h7FFFFFFF, 32'hBFFF7FFE, 1'b1}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        valid = 1'b0;
   logic [4:0]  opcode = '0;
   logic [31:0] rn = '0, rm = '0, ra = '0;
   logic        q_clr = 1'b0;
   logic [31:0] result;
   logic        q_hit, q_flag, done;

   int total = 0;
   int bad = 0;
   logic q_exp = 1'b0;

   always #5 clk = ~clk;

   hdsp_mac u_dut (
      .clk(clk), .rst_n(rst_n), .valid(valid), .opcode(opcode),
      .rn(rn), .rm(rm), .ra(ra), .q_clr(q_clr),
      .result(result), .q_hit(q_hit), .q_flag(q_flag), .done(done)
   );

   function automatic string req_of(logic [4:0] op);
      case (op[4:2])
         3'd0:       return "R1";
         3'd1:       return "R2";
         3'd2, 3'd3: return "R3";
         3'd4, 3'd5: return "R4";
         default:    return "R5";
      endcase
   endfunction

   task automatic check(input logic ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // drive at a negedge, sample at the next negedge after the capturing edge
   task automatic apply(input vec_t v, input logic clr);
      opcode = v.op; rn = v.rn; rm = v.rm; ra = v.ra;
      valid = 1'b1; q_clr = clr;
      @(negedge clk);
      valid = 1'b0; q_clr = 1'b0;
      q_exp = (q_exp && !clr) || v.ovf;
      check(result === v.res, req_of(v.op), "result", result, v.res);
      check(done === 1'b1, "R9", "done", {31'b0, done}, 32'd1);
      check(q_hit === v.ovf, v.ovf ? "R6" : "R7", "q_hit", {31'b0, q_hit}, {31'b0, v.ovf});
      check(q_flag === q_exp, "R8", "q_flag", {31'b0, q_flag}, {31'b0, q_exp});
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++; total++;
      $display("FAIL R9 watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset state
      check(result === 32'h0, "R10", "result", result, 32'h0);
      check({done, q_hit, q_flag} === 3'b000, "R10", "flags", {29'b0, done, q_hit, q_flag}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check(done === 1'b0, "R10", "done idle", {31'b0, done}, 32'd0);

      for (int i = 0; i < NV; i++) begin
         apply(VEC[i], 1'b0);
      end

      // R9 idle cycle: no done, result held
      @(negedge clk);
      check(done === 1'b0, "R9", "idle done", {31'b0, done}, 32'd0);
      check(result === 32'hBFFF7FFE, "R9", "held result", result, 32'hBFFF7FFE);

      // R8 clear alone
      q_clr = 1'b1;
      @(negedge clk);
      q_clr = 1'b0; q_exp = 1'b0;
      check(q_flag === 1'b0, "R8", "cleared", {31'b0, q_flag}, 32'd0);
      check(done === 1'b0, "R9", "clear no done", {31'b0, done}, 32'd0);

      // R7 non-flagging classes keep the flag low, even with large results
      apply(VEC[15], 1'b0);
      apply(VEC[19], 1'b0);
      apply(VEC[4], 1'b0);
      check(q_flag === 1'b0, "R7", "flag stays low", {31'b0, q_flag}, 32'd0);

      // R8 set and clear in the same cycle: set wins
      apply(VEC[7], 1'b1);
      check(q_flag === 1'b1, "R8", "set wins", {31'b0, q_flag}, 32'd1);

      // R9 back-to-back operations
      opcode = VEC[8].op; rn = VEC[8].rn; rm = VEC[8].rm; ra = VEC[8].ra;
      valid = 1'b1;
      @(negedge clk);
      check(done === 1'b1, "R9", "b2b done 1", {31'b0, done}, 32'd1);
      check(result === 32'h27, "R3", "b2b result 1", result, 32'h27);
      opcode = VEC[9].op;
      @(negedge clk);
      valid = 1'b0;
      check(done === 1'b1, "R9", "b2b done 2", {31'b0, done}, 32'd1);
      check(result === 32'h26, "R3", "b2b result 2", result, 32'h26);
      @(negedge clk);
      check(done === 1'b0, "R9", "b2b done end", {31'b0, done}, 32'd0);
      check(q_flag === 1'b1, "R8", "flag kept", {31'b0, q_flag}, 32'd1);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule